// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block gathers interrupt requests from 128 general-purpose input pins and two on-chip event lines (a timer end-of-count pulse and a cable attach/detach indication). It arranges them into seven 32-bit groups. Each group has four registers: polarity, type, enable and status. Every group drives one interrupt line toward a downstream vectored interrupt controller. Every source passes through a two-flop synchronizer. A source can be edge-sensitive or level-sensitive, and active-high or active-low. Status bits are cleared by writing one to them.

Pins do not map straight onto status bits. The 32-pin blocks fill the groups from the highest group down, and inside a group the byte order of the bit index is reversed. Several group bits do not exist in hardware: they read as zero and ignore writes. The register port is a plain single-cycle port with no handshake. A write is taken on the rising clock edge while the write strobe is high, and read data is a combinational function of the address. No streaming interface is involved, so there is no back-pressure.

Top module: `eic_top`

## Requirements
- R1: Register map. The word address is `bus_addr`, and the byte offset is 4 × `bus_addr`. Polarity is at byte 0x80 + 4g, status at 0xA0 + 4g, enable at 0xC0 + 4g and type at 0xE0 + 4g, for group g = 0..6. Polarity, enable and type read back exactly what was last written, restricted to the implemented bits. Any other address reads 0 and ignores writes.
- R2: Pin n (0..127) belongs to group 6 − (n >> 5). Its bit index is (24 − (n & 24)) | (n & 7).
- R3: Every source is synchronized by two flops. A qualifying change is applied between falling clock edges. The status bit is still clear after two rising edges and is set after the third.
- R4: For a type bit of 0 (edge), a polarity bit of 1 sets status on a rising input and a polarity bit of 0 sets status on a falling input. Status then stays set after the input returns.
- R5: Writing 1 to a status bit clears it. Writing 0 has no effect. A set condition in the same cycle as the clear wins.
- R6: For a type bit of 1 (level), status is set on every cycle in which the synchronized input is at its active level (1 for polarity 1, 0 for polarity 0). While the input stays at that level, a clear does not take effect.
- R7: Groups 1 and 2 have no implemented bits. Group 3 bits 4..7 (pins 124..127) are not implemented. In group 0, only bits 0 and 2 are implemented. Bits that are not implemented read 0 in all four registers and cannot be set.
- R8: `irq_out[6 − k]` is high exactly when some bit of group k is set in both the status and enable registers. Status latches while enable is 0, and enabling afterwards raises the output one cycle after the write.
- R9: `timer_evt` is the source of group 0 bit 0 and `usb_evt` is the source of group 0 bit 2.
- R10: After reset, every register reads 0 and all of `irq_out` is 0.
- R11: Changing a polarity bit never produces an edge by itself. The edge detector compares both samples under the current polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 6 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| gpio_in | input | 128 | Asynchronous pin inputs |
| timer_evt | input | 1 | Timer end-of-count event |
| usb_evt | input | 1 | Cable attach/detach event |
| irq_out | output | 7 | Group interrupt lines, bit 6 − k for group k |

## Verification
Assertions check three rules on every cycle:
- a set status bit stays set unless written with one;
- a write-one clears every bit that has no set condition in that cycle;
- an active level or a qualifying edge on an implemented bit always lands in status by the next cycle.

They also check that the unimplemented groups always read zero. The bench scenarios are the only place that shows:
- the pin-to-group and byte-swapped bit mapping;
- the three-edge synchronizer latency;
- the readback masks;
- the reversed group-to-output wiring;
- latching while disabled;
- the absence of false edges when polarity is rewritten.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int EIC_GROUPS = 7;
  localparam int EIC_W      = 32;
  localparam int EIC_PINS   = 128;
  localparam int EIC_DEAD   = 4;    // highest pins with no status bit
  localparam int TIMER_BIT  = 0;
  localparam int USB_BIT    = 2;

  typedef enum logic [1:0] {
    K_POL  = 2'd0,
    K_STAT = 2'd1,
    K_EN   = 2'd2,
    K_TYPE = 2'd3
  } reg_kind_e;

  function automatic int pin_group(int n, int groups);
    return groups - 1 - (n >> 5);
  endfunction

  function automatic int pin_bit(int n);
    return (24 - (n & 24)) | (n & 7);
  endfunction

  function automatic logic [EIC_W-1:0] grp_mask(int g, int groups, int pins, int dead);
    logic [EIC_W-1:0] m;
    m = '0;
    if (g == 0) begin
      m[TIMER_BIT] = 1'b1;
      m[USB_BIT]   = 1'b1;
    end else if (g >= groups - pins / EIC_W) begin
      m = '1;
      for (int p = pins - dead; p < pins; p++)
        if (pin_group(p, groups) == g) m[pin_bit(p)] = 1'b0;
    end
    return m;
  endfunction
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      q    <= '0;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/eic_group.sv
module eic_group
  import eic_pkg::*;
#(
  parameter int         W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic [3:0]   wr_sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] en_q,
  output logic [W-1:0] typ_q,
  output logic         irq
);
  logic [W-1:0] prev_q;
  logic [W-1:0] act, act_prev, hit, clr;

  // both samples judged under the current polarity: no false edge on rewrite
  assign act      = ~(src ^ pol_q);
  assign act_prev = ~(prev_q ^ pol_q);
  assign hit      = MASK & ((typ_q & act) | (~typ_q & act & ~act_prev));
  assign clr      = wr_sel[K_STAT] ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pol_q  <= '0;
      stat_q <= '0;
      en_q   <= '0;
      typ_q  <= '0;
    end else begin
      prev_q <= src;
      if (wr_sel[K_POL])  pol_q <= wdata & MASK;
      if (wr_sel[K_EN])   en_q  <= wdata & MASK;
      if (wr_sel[K_TYPE]) typ_q <= wdata & MASK;
      stat_q <= (stat_q & ~clr) | hit;
    end
  end

  assign irq = |(stat_q & en_q);

  // R4: a set status bit holds unless a clear is written
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel[K_STAT] |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R5: written ones clear every bit without a set condition
  a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel[K_STAT] |=> ((stat_q & $past(wdata & ~(typ_q & act) & ~(~typ_q & act & ~act_prev))) == '0));

  // R6: an active level on an implemented level bit lands in status
  a_r6_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(MASK & typ_q & act) & ~stat_q) == '0));

  // R4: a qualifying edge on an implemented edge bit lands in status
  a_r4_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(MASK & ~typ_q & act & ~act_prev) & ~stat_q) == '0));
endmodule

// File: rtl/eic_top.sv
module eic_top
  import eic_pkg::*;
#(
  parameter int NUM_GROUPS = EIC_GROUPS,
  parameter int GRP_W      = EIC_W,
  parameter int NUM_PINS   = EIC_PINS,
  parameter int DEAD_PINS  = EIC_DEAD,
  parameter int GIDX_W     = $clog2(NUM_GROUPS),
  parameter int ADDR_W     = GIDX_W + 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [GRP_W-1:0]      bus_wdata,
  output logic [GRP_W-1:0]      bus_rdata,
  input  logic [NUM_PINS-1:0]   gpio_in,
  input  logic                  timer_evt,
  input  logic                  usb_evt,
  output logic [NUM_GROUPS-1:0] irq_out
);
  localparam int FLAT_W = NUM_GROUPS * GRP_W;

  logic [NUM_GROUPS-1:0][GRP_W-1:0] raw_src, sync_src;
  logic [NUM_GROUPS-1:0][GRP_W-1:0] pol_v, stat_v, en_v, typ_v;
  logic [NUM_GROUPS-1:0]            grp_irq;
  logic                             in_map;
  logic [1:0]                       kind;
  logic [GIDX_W-1:0]                gsel;

  assign in_map = bus_addr[ADDR_W-1];
  assign kind   = bus_addr[GIDX_W+1:GIDX_W];
  assign gsel   = bus_addr[GIDX_W-1:0];

  // route pins and on-chip events into their group bit positions
  always_comb begin
    raw_src = '0;
    for (int n = 0; n < NUM_PINS; n++)
      raw_src[pin_group(n, NUM_GROUPS)][pin_bit(n)] = gpio_in[n];
    raw_src[0][TIMER_BIT] = timer_evt;
    raw_src[0][USB_BIT]   = usb_evt;
  end

  eic_sync #(.W(FLAT_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_src),
    .q    (sync_src)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [3:0] wsel;
    always_comb begin
      for (int k = 0; k < 4; k++)
        wsel[k] = bus_we && in_map && (int'(gsel) == g) && (int'(kind) == k);
    end

    eic_group #(
      .W   (GRP_W),
      .MASK(grp_mask(g, NUM_GROUPS, NUM_PINS, DEAD_PINS))
    ) u_grp (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (sync_src[g]),
      .wr_sel(wsel),
      .wdata (bus_wdata),
      .pol_q (pol_v[g]),
      .stat_q(stat_v[g]),
      .en_q  (en_v[g]),
      .typ_q (typ_v[g]),
      .irq   (grp_irq[g])
    );

    // reversed wiring: group g feeds output line NUM_GROUPS-1-g
    assign irq_out[NUM_GROUPS-1-g] = grp_irq[g];
  end

  always_comb begin
    bus_rdata = '0;
    if (in_map && int'(gsel) < NUM_GROUPS) begin
      case (reg_kind_e'(kind))
        K_POL:   bus_rdata = pol_v[gsel];
        K_STAT:  bus_rdata = stat_v[gsel];
        K_EN:    bus_rdata = en_v[gsel];
        default: bus_rdata = typ_v[gsel];
      endcase
    end
  end

  // R7: the two groups with no implemented bits always read zero
  a_r7_dead_groups_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_map && (gsel == GIDX_W'(1) || gsel == GIDX_W'(2))) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_eic_top.sv
`timescale 1ns/1ps
module sim_eic_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_we = 1'b0;
  logic [5:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] gpio = '0;
  logic         timer_evt = 1'b0;
  logic         usb_evt = 1'b0;
  logic [6:0]   irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam int POL = 0, STAT = 1, EN = 2, TYP = 3;

  always #2.5 clk = ~clk;

  eic_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio),
    .timer_evt(timer_evt), .usb_evt(usb_evt), .irq_out(irq)
  );

  function automatic int f_grp(int n);
    return 6 - (n >> 5);
  endfunction
  function automatic int f_bit(int n);
    return (24 - (n & 24)) | (n & 7);
  endfunction
  function automatic logic [31:0] f_mask(int g);
    if (g == 0) return 32'h0000_0005;
    if (g == 1 || g == 2) return 32'h0;
    if (g == 3) return 32'hFFFF_FF0F;
    return 32'hFFFF_FFFF;
  endfunction
  function automatic logic [5:0] f_addr(int k, int g);
    return 6'((8'h80 + k * 8'h20 + 4 * g) >> 2);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int k, int g, logic [31:0] d);
    @(negedge clk);
    bus_addr = f_addr(k, g);
    bus_wdata = d;
    bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int k, int g, output logic [31:0] v);
    bus_addr = f_addr(k, g);
    #1 v = bus_rdata;
  endtask

  task automatic settle(int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5.0);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    settle(3);
    rst_n = 1'b1;
    settle(1);

    // R10: reset state
    for (int g = 0; g < 7; g++)
      for (int k = 0; k < 4; k++) begin
        rd(k, g, v);
        chk(v == 32'h0, "R10 reset register", v, 32'h0);
      end
    chk(irq == 7'h0, "R10 reset irq", {25'h0, irq}, 32'h0);

    // R1 / R7: readback masks and write-ignore on unimplemented bits
    for (int g = 0; g < 7; g++) begin
      for (int k = 0; k < 4; k++) begin
        if (k == STAT) continue;
        wr(k, g, 32'hFFFF_FFFF);
        rd(k, g, v);
        chk(v == f_mask(g), "R1 R7 readback mask", v, f_mask(g));
        wr(k, g, 32'h0);
      end
    end
    settle(2);
    for (int g = 0; g < 7; g++) begin
      wr(STAT, g, 32'hFFFF_FFFF);
      rd(STAT, g, v);
      chk(v == 32'h0, "R7 status after clear", v, 32'h0);
    end
    bus_addr = 6'h1F;
    #1 chk(bus_rdata == 32'h0, "R1 unmapped address", bus_rdata, 32'h0);

    // R9: timer event on group 0 bit 0, rising edge
    wr(POL, 0, 32'h1);
    wr(EN, 0, 32'h1);
    timer_evt = 1'b1;
    settle(3);
    rd(STAT, 0, v);
    chk(v == 32'h1, "R9 timer status", v, 32'h1);
    chk(irq[6] == 1'b1, "R8 R9 irq line 6", {31'h0, irq[6]}, 32'h1);
    timer_evt = 1'b0;
    wr(STAT, 0, 32'h1);
    rd(STAT, 0, v);
    chk(v == 32'h0, "R5 timer cleared", v, 32'h0);

    // R9 / R6: cable event on group 0 bit 2, level high
    wr(TYP, 0, 32'h4);
    wr(POL, 0, 32'h4);
    wr(EN, 0, 32'h4);
    usb_evt = 1'b1;
    settle(3);
    rd(STAT, 0, v);
    chk(v == 32'h4, "R9 usb status", v, 32'h4);
    wr(STAT, 0, 32'h4);
    rd(STAT, 0, v);
    chk(v == 32'h4, "R6 level holds through clear", v, 32'h4);
    usb_evt = 1'b0;
    settle(3);
    wr(STAT, 0, 32'h4);
    rd(STAT, 0, v);
    chk(v == 32'h0, "R6 level cleared after removal", v, 32'h0);
    wr(TYP, 0, 32'h0);
    wr(EN, 0, 32'h0);
    wr(POL, 0, 32'h0);
    settle(3);
    wr(STAT, 0, 32'hFFFF_FFFF);

    // R8: pin 0 -> group 6 bit 24, latches while disabled
    wr(POL, 6, 32'h0100_0000);
    gpio[0] = 1'b1;
    settle(3);
    rd(STAT, 6, v);
    chk(v == 32'h0100_0000, "R2 R8 latched while disabled", v, 32'h0100_0000);
    chk(irq[0] == 1'b0, "R8 irq masked", {31'h0, irq[0]}, 32'h0);
    wr(EN, 6, 32'h0100_0000);
    chk(irq[0] == 1'b1, "R8 enable exposes pending", {31'h0, irq[0]}, 32'h1);

    // R11: polarity rewrite makes no edge
    wr(STAT, 6, 32'hFFFF_FFFF);
    wr(POL, 6, 32'h0);
    settle(4);
    rd(STAT, 6, v);
    chk(v == 32'h0, "R11 polarity to low", v, 32'h0);
    wr(POL, 6, 32'h0100_0000);
    settle(4);
    rd(STAT, 6, v);
    chk(v == 32'h0, "R11 polarity to high", v, 32'h0);
    gpio[0] = 1'b0;
    settle(4);
    wr(EN, 6, 32'h0);
    wr(POL, 6, 32'h0);
    settle(3);
    wr(STAT, 6, 32'hFFFF_FFFF);

    // random pins, polarities and types
    for (int it = 0; it < 48; it++) begin
      int n, g, b;
      bit pol, lvl, ok;
      logic [31:0] bm, exp;
      n = (it < 4) ? 124 + it : int'($urandom % 128);
      pol = 1'($urandom % 2);
      lvl = 1'($urandom % 2);
      g = f_grp(n);
      b = f_bit(n);
      ok = (n < 124);
      bm = 32'h1 << b;
      gpio[n] = ~pol;
      settle(4);
      wr(POL, g, pol ? bm : 32'h0);
      wr(TYP, g, lvl ? bm : 32'h0);
      wr(EN, g, bm);
      wr(STAT, g, 32'hFFFF_FFFF);
      rd(STAT, g, v);
      chk(v == 32'h0, "R11 idle after config", v, 32'h0);
      gpio[n] = pol;
      settle(2);
      rd(STAT, g, v);
      chk(v == 32'h0, "R3 not yet after two edges", v, 32'h0);
      settle(1);
      rd(STAT, g, v);
      exp = ok ? bm : 32'h0;
      chk(v == exp, "R2 R4 R6 status bit", v, exp);
      chk(irq[6-g] == ok, "R8 group line", {31'h0, irq[6-g]}, {31'h0, ok});
      wr(STAT, g, bm);
      rd(STAT, g, v);
      exp = (ok && lvl) ? bm : 32'h0;
      chk(v == exp, "R5 R6 after clear", v, exp);
      gpio[n] = ~pol;
      settle(4);
      rd(STAT, g, v);
      exp = (ok && lvl) ? bm : 32'h0;
      chk(v == exp, "R4 R5 no event on return", v, exp);
      wr(STAT, g, 32'hFFFF_FFFF);
      rd(STAT, g, v);
      chk(v == 32'h0, "R5 cleared at idle", v, 32'h0);
      gpio[n] = 1'b0;
      wr(EN, g, 32'h0);
      wr(TYP, g, 32'h0);
      wr(POL, g, 32'h0);
      settle(3);
    end

    finish_run();
  end
endmodule